// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block sits next to a small 8-bit CPU core and decides which of five interrupt request lines it is given next. The sources are two external request lines, two timer overflow flags and one serial port flag. They arrive already detected, one bit each. Software sets three byte-wide registers: a per-source enable mask with a master gate, and two priority bytes. For each source, the bit from the "upper" priority byte and the bit from the "lower" priority byte together give a two-bit level, from 0 to 3.

The block keeps one in-service bit for each level. In a given cycle it picks one candidate: the highest-level pending request that is enabled, and within that level the source that comes first in a fixed polling order. It accepts the candidate only when no handler is running, or when the candidate's level is strictly above the highest level in service. Acceptance marks that level as in service. One cycle later the block raises a strobe to the CPU for a single cycle, with the source index beside it. The CPU sends a one-cycle return pulse when a handler finishes, and this retires the highest level in service, which lets waiting requests of lower or equal level through.

Top module: `irqc_top`

## Requirements
- R1: Source indices follow the polling order: 0 external A, 1 timer A, 2 external B, 3 timer B, 4 serial. Enable bit i and priority bit i in each priority byte belong to source i. `irq_vec` holds the winning index (0 to 4) in the cycle `irq_req` is high.
- R2: When enable-register bit 7 (the master gate) is 0, no request is ever accepted.
- R3: When the master gate is 1, a source can be accepted only if its own enable bit is 1.
- R4: A source's level is {upper byte bit, lower byte bit}, where 3 is the highest. When enabled requests of different levels are pending together, the highest level wins.
- R5: Among pending requests of the winning level, the one with the lowest source index wins.
- R6: While a handler runs, a request is accepted only if its level is strictly greater than the highest level in service. Requests of equal or lower level wait.
- R7: After reset, all three registers read 0, no level is in service, and `irq_req` is 0.
- R8: Register select 0 is the enable byte, 1 is the lower priority byte and 2 is the upper priority byte. Select 3 reads 0 and is not writable. Enable bits 6 and 5 and priority bits 7 to 5 ignore writes and always read 0. A register write takes effect for arbitration from the next cycle.
- R9: A `reti` pulse clears the highest in-service level. With nothing in service it has no effect.
- R10: An acceptance decided from the inputs and state of cycle N sets the in-service bit and raises `irq_req` (with `irq_vec`) in cycle N+1. The strobe lasts one cycle for each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for write (0 enable, 1 lower prio, 2 upper prio) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | 8 | Combinational read data |
| src_req | input | 5 | Request flags, index = polling order |
| reti | input | 1 | Return-from-handler pulse |
| irq_req | output | 1 | One-cycle interrupt strobe to the CPU |
| irq_vec | output | 3 | Index of the accepted source |

## Verification
The bound checker checks, on every clock, the properties that stay true whatever the stimulus. The vector stays in range, and a closed master gate suppresses the strobe. Every strobe follows an enabled pending request and moves the in-service vector strictly upward. A return pulse without a fresh acceptance drops exactly one level. Which source wins among simultaneous requests, the effect of the polling order, and the release of a waiting request after a return can only be seen by comparing the bench's behavioural model against chosen scenarios. The same applies to the masking of reserved bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC    = 5;
    localparam int NLVL    = 4;
    localparam int LVW     = $clog2(NLVL);
    localparam int VECW    = $clog2(NSRC);
    localparam int DW      = 8;
    localparam int GATE_BIT = 7;

    localparam logic [DW-1:0] SRC_MASK = DW'((1 << NSRC) - 1);
    localparam logic [DW-1:0] EN_MASK  = SRC_MASK | (DW'(1) << GATE_BIT);

    typedef enum logic [1:0] {
        SEL_EN   = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            hit;
        logic [LVW-1:0]  lvl;
        logic [VECW-1:0] src;
    } pick_t;

    // Lowest set index of a source mask (polling order).
    function automatic logic [VECW-1:0] first_src(input logic [NSRC-1:0] m);
        logic [VECW-1:0] r;
        logic            found;
        r = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (m[i] && !found) begin
                r = VECW'(i);
                found = 1'b1;
            end
        end
        return r;
    endfunction

    // Highest set index of a level vector.
    function automatic logic [LVW-1:0] top_lvl(input logic [NLVL-1:0] v);
        logic [LVW-1:0] r;
        r = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (v[i]) r = LVW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] plo_q,
    output logic [DW-1:0] phi_q
);

    reg_sel_e wsel, rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            plo_q <= '0;
            phi_q <= '0;
        end else if (wr_en) begin
            case (wsel)
                SEL_EN:  en_q  <= wr_data & EN_MASK;
                SEL_PLO: plo_q <= wr_data & SRC_MASK;
                SEL_PHI: phi_q <= wr_data & SRC_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rsel)
            SEL_EN:  rd_data = en_q;
            SEL_PLO: rd_data = plo_q;
            SEL_PHI: rd_data = phi_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] src_req,
    input  logic [DW-1:0]   en_q,
    input  logic [DW-1:0]   plo_q,
    input  logic [DW-1:0]   phi_q,
    output pick_t           pick
);

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] at_lvl [NLVL];
    logic [NLVL-1:0] lvl_busy;

    assign pend = src_req & en_q[NSRC-1:0] & {NSRC{en_q[GATE_BIT]}};

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign at_lvl[l][s] = pend[s] && ({phi_q[s], plo_q[s]} == LVW'(l));
        end
        assign lvl_busy[l] = |at_lvl[l];
    end

    always_comb begin
        pick.hit = |lvl_busy;
        pick.lvl = top_lvl(lvl_busy);
        pick.src = first_src(at_lvl[pick.lvl]);
    end

endmodule

// File: rtl/irqc_nest.sv
module irqc_nest
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic [LVW-1:0]  acc_lvl,
    input  logic            reti,
    output logic [NLVL-1:0] insvc,
    output logic            busy,
    output logic [LVW-1:0]  cur_lvl
);

    logic [NLVL-1:0] clr_m, set_m;

    assign busy    = |insvc;
    assign cur_lvl = top_lvl(insvc);
    assign clr_m   = (reti && busy) ? (NLVL'(1) << cur_lvl) : '0;
    assign set_m   = accept ? (NLVL'(1) << acc_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) insvc <= '0;
        else     insvc <= (insvc & ~clr_m) | set_m;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic [4:0]  src_req,
    input  logic        reti,
    output logic        irq_req,
    output logic [2:0]  irq_vec
);

    logic [DW-1:0]   en_q, plo_q, phi_q;
    pick_t           pick;
    logic [NLVL-1:0] insvc;
    logic            busy, accept;
    logic [LVW-1:0]  cur_lvl;

    irqc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .en_q(en_q), .plo_q(plo_q), .phi_q(phi_q)
    );

    irqc_arb u_arb (
        .src_req(src_req), .en_q(en_q), .plo_q(plo_q), .phi_q(phi_q),
        .pick(pick)
    );

    assign accept = pick.hit && (!busy || (pick.lvl > cur_lvl));

    irqc_nest u_nest (
        .clk(clk), .rst(rst), .accept(accept), .acc_lvl(pick.lvl),
        .reti(reti), .insvc(insvc), .busy(busy), .cur_lvl(cur_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_req <= accept;
            irq_vec <= accept ? pick.src : irq_vec;
        end
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] src_req,
    input logic       reti,
    input logic       irq_req,
    input logic [2:0] irq_vec,
    input logic [7:0] en_q,
    input logic [3:0] insvc
);

    p_vec_range_r1: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec < 3'd5));

    p_gate_closed_r2: assert property (@(posedge clk) disable iff (rst)
        !en_q[7] |=> !irq_req);

    p_enabled_src_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past((|(src_req & en_q[4:0])) && en_q[7]));

    p_preempt_up_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (insvc > $past(insvc)));

    p_retire_one_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(reti) && !irq_req) |->
            ($countones(insvc) + (($past(insvc) != 4'd0) ? 1 : 0) == $countones($past(insvc))));

    p_strobe_marks_r10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (insvc != 4'd0));

endmodule

bind irqc_top irqc_chk u_chk (
    .clk(clk), .rst(rst), .src_req(src_req), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .en_q(en_q), .insvc(insvc)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic [4:0] src_req = 5'd0;
    logic       reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;

    irqc_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .src_req(src_req), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit [7:0] m_en, m_lo, m_hi;
    bit       m_svc [4];
    bit       exp_req;
    int       exp_vec;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rd(input bit [1:0] s);
        case (s)
            2'd0: return int'(m_en);
            2'd1: return int'(m_lo);
            2'd2: return int'(m_hi);
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_en = 0; m_lo = 0; m_hi = 0;
        for (int i = 0; i < 4; i++) m_svc[i] = 0;
        exp_req = 0; exp_vec = 0;
    endtask

    // One cycle: compare at negedge, then drive and predict the next edge.
    task automatic step(input bit [4:0] rq, input bit rt, input bit we, input bit [1:0] ws,
                        input bit [7:0] wd, input bit [1:0] rs, input string tag);
        int cur, best_l, best_s;
        @(negedge clk);
        chk(tag, "irq_req", int'(irq_req), int'(exp_req));
        if (exp_req) chk(tag, "irq_vec", int'(irq_vec), exp_vec);
        chk(tag, "rd_data", int'(rd_data), exp_rd(rd_sel));
        src_req = rq; reti = rt; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
        cur = -1;
        for (int i = 0; i < 4; i++) if (m_svc[i]) cur = i;
        best_l = -1; best_s = -1;
        for (int s = 0; s < 5; s++) begin
            if (rq[s] && m_en[7] && m_en[s]) begin
                int l;
                l = 2 * int'(m_hi[s]) + int'(m_lo[s]);
                if (l > best_l) begin best_l = l; best_s = s; end
            end
        end
        exp_req = (best_s >= 0) && (best_l > cur);
        if (exp_req) exp_vec = best_s;
        if (rt && cur >= 0) m_svc[cur] = 0;
        if (exp_req) m_svc[best_l] = 1;
        if (we) begin
            case (ws)
                2'd0: m_en = wd & 8'h9F;
                2'd1: m_lo = wd & 8'h1F;
                2'd2: m_hi = wd & 8'h1F;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input bit [1:0] s, input bit [7:0] d, input string tag);
        step(5'd0, 0, 1, s, d, s, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(5'd0, 0, 0, 2'd0, 8'd0, 2'd0, tag);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 4; i++) step(5'd0, 1, 0, 2'd0, 8'd0, 2'd0, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: reset values of every register and the strobe
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd1, "R7");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd2, "R7");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd3, "R7");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd0, "R7");

        // R2: sources enabled but gate closed
        wr(2'd0, 8'h1F, "R2");
        for (int i = 0; i < 4; i++) step(5'h1F, 0, 0, 2'd0, 8'd0, 2'd0, "R2");

        // R3: gate open, only timer A enabled; others requested
        wr(2'd0, 8'h82, "R3");
        step(5'h1D, 0, 0, 2'd0, 8'd0, 2'd0, "R3");
        step(5'h1D, 0, 0, 2'd0, 8'd0, 2'd0, "R3");
        step(5'h02, 0, 0, 2'd0, 8'd0, 2'd0, "R3");
        step(5'h00, 0, 0, 2'd0, 8'd0, 2'd0, "R3");
        drain("R9");

        // R1: each source alone gives its own index
        wr(2'd0, 8'h9F, "R1");
        for (int s = 0; s < 5; s++) begin
            step(5'(1 << s), 0, 0, 2'd0, 8'd0, 2'd0, "R1");
            step(5'd0, 0, 0, 2'd0, 8'd0, 2'd0, "R10");
            step(5'd0, 1, 0, 2'd0, 8'd0, 2'd0, "R9");
            idle(1, "R10");
        end

        // R5: all at level 0, polling order decides; R6: equal level waits
        step(5'h1C, 0, 0, 2'd0, 8'd0, 2'd0, "R5");
        step(5'h1C, 0, 0, 2'd0, 8'd0, 2'd0, "R5");
        step(5'h1C, 0, 0, 2'd0, 8'd0, 2'd0, "R6");
        step(5'h1C, 0, 0, 2'd0, 8'd0, 2'd0, "R6");
        // raise serial to level 3 while level 0 runs -> preempts
        step(5'h18, 0, 1, 2'd1, 8'h10, 2'd1, "R8");
        step(5'h18, 0, 1, 2'd2, 8'h10, 2'd2, "R4");
        step(5'h18, 0, 0, 2'd0, 8'd0, 2'd0, "R6");
        step(5'h08, 0, 0, 2'd0, 8'd0, 2'd0, "R6");
        step(5'h08, 0, 0, 2'd0, 8'd0, 2'd0, "R6");
        // R9: retire level 3, then level 0 -> timer B taken
        step(5'h08, 1, 0, 2'd0, 8'd0, 2'd0, "R9");
        step(5'h08, 1, 0, 2'd0, 8'd0, 2'd0, "R9");
        step(5'h08, 0, 0, 2'd0, 8'd0, 2'd0, "R9");
        step(5'h00, 0, 0, 2'd0, 8'd0, 2'd0, "R9");
        drain("R9");

        // R4: different levels at once: ext A lvl1, ext B lvl2, timer B lvl0
        wr(2'd1, 8'h01, "R4");
        wr(2'd2, 8'h04, "R4");
        step(5'h0D, 0, 0, 2'd0, 8'd0, 2'd0, "R4");
        step(5'h09, 0, 0, 2'd0, 8'd0, 2'd0, "R4");
        step(5'h09, 0, 0, 2'd0, 8'd0, 2'd0, "R6");
        step(5'h09, 1, 0, 2'd0, 8'd0, 2'd0, "R9");
        step(5'h08, 0, 0, 2'd0, 8'd0, 2'd0, "R9");
        step(5'h08, 1, 0, 2'd0, 8'd0, 2'd0, "R9");
        step(5'h00, 0, 0, 2'd0, 8'd0, 2'd0, "R9");
        drain("R9");

        // R8: reserved bits and unused select
        wr(2'd0, 8'hFF, "R8");
        wr(2'd1, 8'hFF, "R8");
        wr(2'd2, 8'hFF, "R8");
        wr(2'd3, 8'hFF, "R8");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd0, "R8");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd1, "R8");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd2, "R8");
        step(5'd0, 0, 0, 2'd0, 8'd0, 2'd0, "R8");

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            bit [4:0] rq;
            bit rt, we;
            rq = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
            rt = ($urandom_range(0, 3) == 0);
            we = ($urandom_range(0, 15) == 0);
            step(rq, rt, we, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                 2'($urandom_range(0, 3)), "R10");
        end
        idle(2, "R10");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL R10 watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule